// File: doc/BRIEF.md
# Display Channel Mode Switch Detector

This block selects the operating mode of a display data channel. The channel has two modes: a transmit-only mode, where data is clocked out by a slow external timing pulse, and a two-way mode, where a serial bus slave engine (not part of this block) takes over. The detector starts in transmit-only mode whenever the channel is enabled. It watches the already synchronized serial clock line and moves to two-way mode by itself once that line has stayed low for longer than a fixed time.

The low time is counted in system clock cycles. The threshold in cycles is derived from two parameters, the system clock period and the minimum low time, both given in nanoseconds. The move happens as soon as the count goes past the threshold; the detector does not wait for the clock line to rise again. A shorter low pulse leaves no trace. Software can also force two-way mode at any time, send the channel back to transmit-only mode, and clear a sticky flag that records each automatic switch. All control inputs are single-cycle strobes and all outputs are plain levels. No data flows through the block, so it has no valid/ready interface.

Top module: `ddc_mode_switch`

## Requirements
- R1: After reset, and whenever the channel has just been enabled, `bidir_mode` is 0 (transmit-only mode) and `auto_sw_flag` is 0 after reset.
- R2: While `chan_off` is 1 the channel is disabled: `bidir_mode` stays 0 whatever `scl_in`, `sw_force_bidir` or `sw_return_uni` do, and no low time is counted.
- R3: With THRESH_CYC = ceil(LOW_NS / CLK_NS), a low run on `scl_in` seen on at most THRESH_CYC consecutive rising edges of `clk` does not change the mode, and any high sample restarts the count from zero.
- R4: On the (THRESH_CYC+1)-th consecutive rising edge that samples `scl_in` low, `bidir_mode` becomes 1 at that edge, while `scl_in` is still low.
- R5: A one-cycle `sw_force_bidir` strobe while enabled sets `bidir_mode` to 1 at the next rising edge.
- R6: A `sw_return_uni` strobe while enabled sets `bidir_mode` to 0 at the next rising edge. It wins over `sw_force_bidir` and over an automatic detection in the same cycle.
- R7: When `sw_force_bidir` and an automatic detection happen in the same cycle (and `sw_return_uni` is 0), `bidir_mode` becomes 1.
- R8: One low pulse causes at most one detection: after a detection, further low samples do nothing until `scl_in` has been sampled high.
- R9: `auto_sw_flag` is set by a detection that occurs while in transmit-only mode without a `sw_return_uni` strobe. It stays set until a `sw_clr_flag` strobe clears it, and a set in the same cycle wins over the clear. A `sw_force_bidir` strobe alone never sets it.
- R10: Setting `chan_off` to 1 returns `bidir_mode` to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_off | input | 1 | Channel disable, active high; 0 enables the channel |
| scl_in | input | 1 | Serial clock line, already synchronized to `clk` |
| sw_force_bidir | input | 1 | Software strobe: enter two-way mode |
| sw_return_uni | input | 1 | Software strobe: return to transmit-only mode |
| sw_clr_flag | input | 1 | Software strobe: clear `auto_sw_flag` |
| bidir_mode | output | 1 | 1 = two-way mode, 0 = transmit-only mode |
| auto_sw_flag | output | 1 | Sticky: an automatic switch to two-way mode occurred |

## Verification
The bench builds the block with CLK_NS = 20 and LOW_NS = 100, so the threshold is five cycles. With that value, low runs of exactly five and exactly six samples take only a few cycles, and the bench can land strobes on the exact detection cycle to test the priority rules. Longer held-low stretches after a detection are cheap to run, which lets the bench check that a single pulse switches the mode only once.

// File: rtl/ddc_sw_pkg.sv
package ddc_sw_pkg;
  typedef enum logic {
    MODE_UNI   = 1'b0,
    MODE_BIDIR = 1'b1
  } chan_mode_e;

  function automatic int unsigned cycles_for(input int unsigned ns, input int unsigned period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction
endpackage

// File: rtl/ddc_low_timer.sv
module ddc_low_timer #(
  parameter int unsigned THRESH_CYC = 25,
  localparam int unsigned CW = $clog2(THRESH_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic scl_in,
  output logic detect
);
  logic [CW-1:0] low_cnt;
  logic          fired;

  // A detection fires on the low sample that comes after THRESH_CYC low samples.
  assign detect = active && !scl_in && !fired && (low_cnt == CW'(THRESH_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      fired   <= 1'b0;
    end else if (!active || scl_in) begin
      low_cnt <= '0;
      fired   <= 1'b0;
    end else begin
      if (low_cnt != CW'(THRESH_CYC)) low_cnt <= low_cnt + 1'b1;
      if (detect) fired <= 1'b1;
    end
  end
endmodule

// File: rtl/ddc_mode_ctrl.sv
module ddc_mode_ctrl
  import ddc_sw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic detect,
  input  logic sw_force_bidir,
  input  logic sw_return_uni,
  input  logic sw_clr_flag,
  output logic bidir_mode,
  output logic auto_sw_flag
);
  chan_mode_e mode_q, mode_d;
  logic       flag_d;
  logic       auto_set;

  assign auto_set = active && detect && (mode_q == MODE_UNI) && !sw_return_uni;

  always_comb begin
    mode_d = mode_q;
    if (!active)                        mode_d = MODE_UNI;
    else if (sw_return_uni)             mode_d = MODE_UNI;
    else if (sw_force_bidir || detect)  mode_d = MODE_BIDIR;
  end

  always_comb begin
    flag_d = auto_sw_flag;
    if (sw_clr_flag) flag_d = 1'b0;
    if (auto_set)    flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MODE_UNI;
      auto_sw_flag <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      auto_sw_flag <= flag_d;
    end
  end

  assign bidir_mode = (mode_q == MODE_BIDIR);
endmodule

// File: rtl/ddc_mode_switch.sv
module ddc_mode_switch
  import ddc_sw_pkg::*;
#(
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned LOW_NS = 500,
  localparam int unsigned THRESH_CYC = cycles_for(LOW_NS, CLK_NS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_off,
  input  logic scl_in,
  input  logic sw_force_bidir,
  input  logic sw_return_uni,
  input  logic sw_clr_flag,
  output logic bidir_mode,
  output logic auto_sw_flag
);
  logic active;
  logic detect;

  assign active = !chan_off;

  ddc_low_timer #(.THRESH_CYC(THRESH_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .scl_in (scl_in),
    .detect (detect)
  );

  ddc_mode_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .active         (active),
    .detect         (detect),
    .sw_force_bidir (sw_force_bidir),
    .sw_return_uni  (sw_return_uni),
    .sw_clr_flag    (sw_clr_flag),
    .bidir_mode     (bidir_mode),
    .auto_sw_flag   (auto_sw_flag)
  );
endmodule

// File: rtl/ddc_mode_switch_chk.sv
module ddc_mode_switch_chk #(
  parameter int unsigned THRESH_CYC = 25,
  localparam int unsigned CW = $clog2(THRESH_CYC + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic chan_off,
  input logic scl_in,
  input logic sw_force_bidir,
  input logic sw_return_uni,
  input logic sw_clr_flag,
  input logic bidir_mode,
  input logic auto_sw_flag
);
  logic [CW-1:0] lows;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lows <= '0;
    else if (chan_off || scl_in)  lows <= '0;
    else if (lows != CW'(THRESH_CYC + 1)) lows <= lows + 1'b1;
  end

  p_off_uni_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_off |=> !bidir_mode);

  p_return_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_off && sw_return_uni) |=> !bidir_mode);

  p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_off && sw_force_bidir && !sw_return_uni) |=> bidir_mode);

  p_long_low_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bidir_mode) && !$past(sw_force_bidir)) |-> (lows == CW'(THRESH_CYC + 1)));

  p_flag_with_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_sw_flag) |-> $rose(bidir_mode));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(auto_sw_flag) |-> $past(sw_clr_flag));
endmodule

bind ddc_mode_switch ddc_mode_switch_chk #(.THRESH_CYC(THRESH_CYC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .chan_off       (chan_off),
  .scl_in         (scl_in),
  .sw_force_bidir (sw_force_bidir),
  .sw_return_uni  (sw_return_uni),
  .sw_clr_flag    (sw_clr_flag),
  .bidir_mode     (bidir_mode),
  .auto_sw_flag   (auto_sw_flag)
);

// File: tb/ddc_mode_switch_bench.sv
module ddc_mode_switch_bench;
  localparam int CLK_PERIOD = 20;
  localparam int TH = 5;  // ceil(100/20)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_off = 1'b1;
  logic scl_in = 1'b1;
  logic sw_force_bidir = 1'b0;
  logic sw_return_uni = 1'b0;
  logic sw_clr_flag = 1'b0;
  logic bidir_mode, auto_sw_flag;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddc_mode_switch #(.CLK_NS(20), .LOW_NS(100)) u_ddc_mode_switch (
    .clk(clk), .rst_n(rst_n), .chan_off(chan_off), .scl_in(scl_in),
    .sw_force_bidir(sw_force_bidir), .sw_return_uni(sw_return_uni),
    .sw_clr_flag(sw_clr_flag), .bidir_mode(bidir_mode), .auto_sw_flag(auto_sw_flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_run(input int n);
    scl_in = 1'b0;
    cyc(n);
  endtask

  task automatic go_high();
    scl_in = 1'b1;
    cyc(2);
  endtask

  task automatic strobe_return();
    sw_return_uni = 1'b1; cyc(1); sw_return_uni = 1'b0;
  endtask

  task automatic t_reset_r1();
    check("R1 mode after reset", bidir_mode, 1'b0);
    check("R1 flag after reset", auto_sw_flag, 1'b0);
  endtask

  task automatic t_disabled_r2();
    low_run(TH + 3);
    check("R2 long low while disabled", bidir_mode, 1'b0);
    sw_force_bidir = 1'b1; cyc(1); sw_force_bidir = 1'b0;
    check("R2 force while disabled", bidir_mode, 1'b0);
    go_high();
    chan_off = 1'b0; cyc(2);
    check("R1 uni right after enable", bidir_mode, 1'b0);
  endtask

  task automatic t_short_r3();
    low_run(TH);
    check("R3 low of TH samples", bidir_mode, 1'b0);
    scl_in = 1'b1; cyc(1);
    low_run(TH);
    check("R3 count restarts after high", bidir_mode, 1'b0);
    go_high();
  endtask

  task automatic t_long_r4();
    low_run(TH + 1);
    check("R4 switch at TH+1 while low", bidir_mode, 1'b1);
    check("R9 flag set by auto switch", auto_sw_flag, 1'b1);
    cyc(3);
    check("R9 flag sticky", auto_sw_flag, 1'b1);
    go_high();
    sw_clr_flag = 1'b1; cyc(1); sw_clr_flag = 1'b0;
    check("R9 flag cleared", auto_sw_flag, 1'b0);
    check("R9 mode kept on flag clear", bidir_mode, 1'b1);
    strobe_return();
    check("R6 return to uni", bidir_mode, 1'b0);
  endtask

  task automatic t_once_r8();
    low_run(TH + 1);
    check("R8 first detection", bidir_mode, 1'b1);
    strobe_return();
    cyc(TH + 4);
    check("R8 no repeat within same pulse", bidir_mode, 1'b0);
    go_high();
    low_run(TH + 1);
    check("R8 new pulse detects again", bidir_mode, 1'b1);
    go_high();
    sw_clr_flag = 1'b1; cyc(1); sw_clr_flag = 1'b0;
    strobe_return();
  endtask

  task automatic t_force_r5();
    sw_force_bidir = 1'b1; cyc(1); sw_force_bidir = 1'b0;
    check("R5 force to bidir", bidir_mode, 1'b1);
    check("R9 force leaves flag clear", auto_sw_flag, 1'b0);
    sw_force_bidir = 1'b1; sw_return_uni = 1'b1; cyc(1);
    sw_force_bidir = 1'b0; sw_return_uni = 1'b0;
    check("R6 return beats force", bidir_mode, 1'b0);
  endtask

  task automatic t_return_vs_detect_r6();
    low_run(TH);
    sw_return_uni = 1'b1; cyc(1); sw_return_uni = 1'b0;
    check("R6 return beats detection", bidir_mode, 1'b0);
    check("R6 no flag when return wins", auto_sw_flag, 1'b0);
    go_high();
  endtask

  task automatic t_both_r7();
    low_run(TH);
    sw_force_bidir = 1'b1; cyc(1); sw_force_bidir = 1'b0;
    check("R7 force plus detect", bidir_mode, 1'b1);
    check("R7 flag on detect", auto_sw_flag, 1'b1);
    go_high();
    sw_clr_flag = 1'b1; cyc(1); sw_clr_flag = 1'b0;
    strobe_return();
  endtask

  task automatic t_set_wins_r9();
    low_run(TH);
    sw_clr_flag = 1'b1; cyc(1); sw_clr_flag = 1'b0;
    check("R9 set wins over clear", auto_sw_flag, 1'b1);
    go_high();
  endtask

  task automatic t_disable_r10();
    check("R10 precondition bidir", bidir_mode, 1'b1);
    chan_off = 1'b1; cyc(1);
    check("R10 disable returns uni", bidir_mode, 1'b0);
    chan_off = 1'b0; cyc(2);
    check("R10 stays uni after re-enable", bidir_mode, 1'b0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset_r1();
    t_disabled_r2();
    t_short_r3();
    t_long_r4();
    t_once_r8();
    t_force_r5();
    t_return_vs_detect_r6();
    t_both_r7();
    t_set_wins_r9();
    t_disable_r10();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule